// File: doc/BRIEF.md
# Seven-Segment Space-Vector Pulse Generator

This block turns a sector number and three dwell times into the gate pattern for a three-phase, two-level inverter bridge. A single counter sweeps one symmetric switching period of `2*(T0+T1+T2)` clock ticks. The three upper-leg signals step through a fixed sequence: all legs low, the two adjacent active vectors, all legs high, and then the same steps in reverse. Each leg is raised and dropped by comparing the counter against sums of `T0/2`, `T1` and `T2`. Which sums apply to which leg depends on the sector, so the order of the edges changes from sector to sector. Each lower-leg output is the plain inverse of its upper-leg partner. Dead time is not inserted.

A controller presents a sector and three times with a one-cycle load strobe at any moment. The values are held in a staging register and take effect only where one period ends and the next begins. A period therefore never mixes old and new settings.

Top module: `svpwm_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, every upper output is 0 and every lower output is 1. The staged and active settings are cleared, which means sector 0 and all times 0.
- R2: The counter takes the values 1 up to P, where P = 2*(T0+T1+T2) of the active settings, and then starts again at 1. For the leading leg, successive rising edges are therefore exactly P cycles apart. When P is 0, the counter stays at 1 and the end of a period is seen on every cycle.
- R3: Let h = floor(T0/2) and B = h+T1+T2. Upper bit 0 is leg A, bit 1 is leg B and bit 2 is leg C. Each leg has an active share x, and it is high for the counts c with B-x < c <= B+T0+x. The output is registered, so the pattern for count c appears one cycle after the counter holds c.
- R4: The active share x of each leg, listed as (A, B, C), is:
  - sector 1: (T1+T2, T2, 0)
  - sector 2: (T1, T1+T2, 0)
  - sector 3: (0, T1+T2, T2)
  - sector 4: (0, T1, T1+T2)
  - sector 5: (T2, 0, T1+T2)
  - sector 6: (T1+T2, 0, T1)

  Over one full period, each leg is high for T0+2x cycles.
- R5: Each lower output is the inverse of the upper output of the same leg on every cycle.
- R6: A load sets new staged settings, and a later load in the same period replaces them. The staged settings become active only when the counter wraps. A load that is sampled on the wrap cycle itself becomes active at once for the period that begins there.
- R7: When T0 is odd, the opening all-low interval lasts h counts and the closing all-low interval lasts h+1 counts. The all-high interval lasts T0 counts.
- R8: A sector value of 0 or 7 holds all upper outputs low for every period that uses it.
- R9: In a valid sector n, the upper pattern on any cycle is one of four values: all low, all high, the vector of sector n, or the vector of sector n+1 (sector 6 wraps to 1). The vector codes, written as bits C,B,A, are:
  - V1 = 001
  - V2 = 011
  - V3 = 010
  - V4 = 110
  - V5 = 100
  - V6 = 101

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures the sector and times |
| sector | input | 3 | Sector number, 1 to 6 |
| t0 | input | TW | Total zero-vector time |
| t1 | input | TW | Time of the first active vector |
| t2 | input | TW | Time of the second active vector |
| pwm_hi | output | 3 | Upper-leg gates, bit 0 = A, bit 1 = B, bit 2 = C |
| pwm_lo | output | 3 | Lower-leg gates, the inverse of pwm_hi |

## Verification
The load strobe and the end of a period can fall in the same cycle. In that cycle the staging path and the wrap path both want to write the active settings. The bench watches its own model of the counter and raises the strobe exactly on the cycle before the wrap edge. The new settings must then govern the period that starts at that edge, and the output pattern is compared against this cycle by cycle. A second case places two loads inside one period, and only the later one may appear after the wrap.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef enum logic [1:0] {
    LEG_A = 2'd0,
    LEG_B = 2'd1,
    LEG_C = 2'd2
  } leg_e;

  localparam int NUM_LEGS = 3;

  function automatic logic sector_ok(input logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd6);
  endfunction

  // Leg whose on-window is widest in a given sector (spans all others).
  function automatic int lead_leg(input logic [2:0] s);
    case (s)
      3'd2, 3'd3: return int'(LEG_B);
      3'd4, 3'd5: return int'(LEG_C);
      default:    return int'(LEG_A);
    endcase
  endfunction

endpackage

// File: rtl/svpwm_param_latch.sv
module svpwm_param_latch #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    sector_in,
  input  logic [TW-1:0] t0_in,
  input  logic [TW-1:0] t1_in,
  input  logic [TW-1:0] t2_in,
  input  logic          wrap,
  output logic [2:0]    act_sector,
  output logic [TW-1:0] act_t0,
  output logic [TW-1:0] act_t1,
  output logic [TW-1:0] act_t2
);

  logic [2:0]    stg_sector;
  logic [TW-1:0] stg_t0, stg_t1, stg_t2;
  logic          stg_valid;

  // Staging register: captures every strobe outside a wrap cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_valid  <= 1'b0;
      stg_sector <= '0;
      stg_t0     <= '0;
      stg_t1     <= '0;
      stg_t2     <= '0;
    end else if (wrap) begin
      stg_valid <= 1'b0;
    end else if (load) begin
      stg_valid  <= 1'b1;
      stg_sector <= sector_in;
      stg_t0     <= t0_in;
      stg_t1     <= t1_in;
      stg_t2     <= t2_in;
    end
  end

  // Active register: written only at the period boundary (R6).
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sector <= '0;
      act_t0     <= '0;
      act_t1     <= '0;
      act_t2     <= '0;
    end else if (wrap) begin
      if (load) begin
        act_sector <= sector_in;
        act_t0     <= t0_in;
        act_t1     <= t1_in;
        act_t2     <= t2_in;
      end else if (stg_valid) begin
        act_sector <= stg_sector;
        act_t0     <= stg_t0;
        act_t1     <= stg_t1;
        act_t2     <= stg_t2;
      end
    end
  end

  // R6: settings in force never change inside a period
  assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_sector) && $stable(act_t0) && $stable(act_t1) && $stable(act_t2));

endmodule

// File: rtl/svpwm_period_counter.sv
module svpwm_period_counter #(
  parameter int TW = 8,
  parameter int CW = TW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] t0,
  input  logic [TW-1:0] t1,
  input  logic [TW-1:0] t2,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  function automatic logic [CW-1:0] period_len(input logic [TW-1:0] a,
                                               input logic [TW-1:0] b,
                                               input logic [TW-1:0] c);
    logic [CW-1:0] s;
    s = CW'(a) + CW'(b) + CW'(c);
    return s << 1;
  endfunction

  logic [CW-1:0] period;

  assign period = period_len(t0, t1, t2);
  assign wrap   = (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= CW'(1);
    else if (wrap) cnt <= CW'(1);
    else           cnt <= cnt + CW'(1);
  end

  // R2: restart at 1 after the last count
  assert_restart_at_one_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == CW'(1)));

  // R2: strictly single-step inside a period
  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (cnt == $past(cnt) + CW'(1)));

  // R2: count zero is never used
  assert_no_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/svpwm_leg_compare.sv
module svpwm_leg_compare
  import svpwm_pkg::*;
#(
  parameter int TW = 8,
  parameter int CW = TW + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          sector,
  input  logic [TW-1:0]       t0,
  input  logic [TW-1:0]       t1,
  input  logic [TW-1:0]       t2,
  input  logic [CW-1:0]       cnt,
  output logic [NUM_LEGS-1:0] up
);

  // Share of the active-vector time that a leg is high for in one half.
  function automatic logic [CW-1:0] leg_share(input logic [2:0] s, input int leg,
                                              input logic [TW-1:0] a,
                                              input logic [TW-1:0] b);
    logic [CW-1:0] ea, eb, ab;
    ea = CW'(a);
    eb = CW'(b);
    ab = ea + eb;
    case (s)
      3'd1: return (leg == 0) ? ab : (leg == 1) ? eb : '0;
      3'd2: return (leg == 0) ? ea : (leg == 1) ? ab : '0;
      3'd3: return (leg == 0) ? '0 : (leg == 1) ? ab : eb;
      3'd4: return (leg == 0) ? '0 : (leg == 1) ? ea : ab;
      3'd5: return (leg == 0) ? eb : (leg == 1) ? '0 : ab;
      3'd6: return (leg == 0) ? ab : (leg == 1) ? '0 : ea;
      default: return '0;
    endcase
  endfunction

  // Last count before the leg rises; half of T0 taken by right shift (R7).
  function automatic logic [CW-1:0] rise_after(input logic [TW-1:0] z,
                                               input logic [TW-1:0] a,
                                               input logic [TW-1:0] b,
                                               input logic [CW-1:0] x);
    return CW'(z >> 1) + CW'(a) + CW'(b) - x;
  endfunction

  function automatic logic [CW-1:0] fall_at(input logic [CW-1:0] r,
                                            input logic [TW-1:0] z,
                                            input logic [CW-1:0] x);
    return r + CW'(z) + (x << 1);
  endfunction

  logic                sec_valid;
  logic [NUM_LEGS-1:0] up_next;

  assign sec_valid = sector_ok(sector);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic [CW-1:0] share, lo_edge, hi_edge;
    assign share      = leg_share(sector, g, t1, t2);
    assign lo_edge    = rise_after(t0, t1, t2, share);
    assign hi_edge    = fall_at(lo_edge, t0, share);
    assign up_next[g] = sec_valid && (cnt > lo_edge) && (cnt <= hi_edge);
  end

  always_ff @(posedge clk) begin
    if (rst) up <= '0;
    else     up <= up_next;
  end

  // R8: an unusable sector keeps every upper leg low
  assert_bad_sector_off_R8: assert property (@(posedge clk) disable iff (rst)
    !sec_valid |=> (up == '0));

  // R9: the widest leg covers every other leg's on-time
  assert_lead_covers_R9: assert property (@(posedge clk) disable iff (rst)
    (up != '0) |-> up[lead_leg($past(sector))]);

endmodule

// File: rtl/svpwm_gen.sv
module svpwm_gen
  import svpwm_pkg::*;
#(
  parameter int TW = 8,
  localparam int CW = TW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    sector,
  input  logic [TW-1:0] t0,
  input  logic [TW-1:0] t1,
  input  logic [TW-1:0] t2,
  output logic [2:0]    pwm_hi,
  output logic [2:0]    pwm_lo
);

  logic [2:0]    act_sector;
  logic [TW-1:0] act_t0, act_t1, act_t2;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic [NUM_LEGS-1:0] up;

  svpwm_param_latch #(.TW(TW)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .sector_in  (sector),
    .t0_in      (t0),
    .t1_in      (t1),
    .t2_in      (t2),
    .wrap       (wrap),
    .act_sector (act_sector),
    .act_t0     (act_t0),
    .act_t1     (act_t1),
    .act_t2     (act_t2)
  );

  svpwm_period_counter #(.TW(TW), .CW(CW)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .t0   (act_t0),
    .t1   (act_t1),
    .t2   (act_t2),
    .cnt  (cnt),
    .wrap (wrap)
  );

  svpwm_leg_compare #(.TW(TW), .CW(CW)) u_legs (
    .clk    (clk),
    .rst    (rst),
    .sector (act_sector),
    .t0     (act_t0),
    .t1     (act_t1),
    .t2     (act_t2),
    .cnt    (cnt),
    .up     (up)
  );

  assign pwm_hi = up;
  assign pwm_lo = ~up;

  // R1: outputs settle to the safe state right after reset
  assert_reset_safe_R1: assert property (@(posedge clk)
    $past(rst) |-> (pwm_hi == 3'b000));

endmodule

// File: tb/svpwm_gen_tb.sv
module svpwm_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [2:0]    sector = '0;
  logic [TW-1:0] t0 = '0, t1 = '0, t2 = '0;
  logic [2:0]    pwm_hi, pwm_lo;

  svpwm_gen #(.TW(TW)) u_dut (
    .clk(clk), .rst(rst), .load(load), .sector(sector),
    .t0(t0), .t1(t1), .t2(t2), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    mon_en = 0;
  string cur_tag = "R3";

  // ---------------- reference model ----------------
  int m_cnt, m_sec, m_t0, m_t1, m_t2;
  int p_sec, p_t0, p_t1, p_t2;
  bit p_v;
  logic [2:0] m_out;
  int m_osec;

  function automatic int per_of(int a, int b, int c);
    return 2 * (a + b + c);
  endfunction

  // Vector code, bit0 = A, bit1 = B, bit2 = C
  function automatic logic [2:0] vec_code(int s);
    case (s)
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b010;
      4: return 3'b110;
      5: return 3'b100;
      6: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int next_sec(int s);
    return (s == 6) ? 1 : s + 1;
  endfunction

  // A leg is high around the centre of the all-high interval, widened by its
  // share of the active vectors it belongs to.
  function automatic logic [2:0] expect_upper(int s, int z, int a, int b, int c);
    logic [2:0] r, vn, vm;
    int base, x, d;
    r = 3'b000;
    if (s < 1 || s > 6) return r;
    vn = vec_code(s);
    vm = vec_code(next_sec(s));
    base = z / 2 + a + b;
    d = c - base;
    for (int k = 0; k < 3; k++) begin
      x = (vn[k] ? a : 0) + (vm[k] ? b : 0);
      r[k] = (d > -x) && (d <= z + x);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 1; m_sec <= 0; m_t0 <= 0; m_t1 <= 0; m_t2 <= 0;
      p_sec <= 0; p_t0 <= 0; p_t1 <= 0; p_t2 <= 0; p_v <= 0;
      m_out <= 3'b000; m_osec <= 0;
    end else begin
      m_out  <= expect_upper(m_sec, m_t0, m_t1, m_t2, m_cnt);
      m_osec <= m_sec;
      if (m_cnt >= per_of(m_t0, m_t1, m_t2)) begin
        m_cnt <= 1;
        p_v   <= 0;
        if (load) begin
          m_sec <= int'(sector); m_t0 <= int'(t0); m_t1 <= int'(t1); m_t2 <= int'(t2);
        end else if (p_v) begin
          m_sec <= p_sec; m_t0 <= p_t0; m_t1 <= p_t1; m_t2 <= p_t2;
        end
      end else begin
        m_cnt <= m_cnt + 1;
        if (load) begin
          p_v <= 1;
          p_sec <= int'(sector); p_t0 <= int'(t0); p_t1 <= int'(t1); p_t2 <= int'(t2);
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk(pwm_hi == m_out, cur_tag, int'(pwm_hi), int'(m_out));
      chk(pwm_lo == ~pwm_hi, "R5 complement", int'(pwm_lo), int'(~pwm_hi));
      if (m_osec >= 1 && m_osec <= 6)
        chk(pwm_hi == 3'b000 || pwm_hi == 3'b111 || pwm_hi == vec_code(m_osec) ||
            pwm_hi == vec_code(next_sec(m_osec)), "R9 vector set",
            int'(pwm_hi), int'(vec_code(m_osec)));
      else
        chk(pwm_hi == 3'b000, "R8 invalid sector", int'(pwm_hi), 0);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_load(int s, int a, int b, int c);
    @(negedge clk);
    load = 1'b1; sector = 3'(s); t0 = TW'(a); t1 = TW'(b); t2 = TW'(c);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_wraps(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (m_cnt != 1) @(negedge clk);
      if (per_of(m_t0, m_t1, m_t2) > 0) @(negedge clk);
    end
  endtask

  // Count high cycles of each leg over one whole period (R4).
  task automatic check_duty(int s, int a, int b, int c);
    int p, hi_a, hi_b, hi_c;
    logic [2:0] vn, vm;
    do_load(s, a, b, c);
    wait_wraps(3);
    p = per_of(a, b, c);
    hi_a = 0; hi_b = 0; hi_c = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      hi_a += int'(pwm_hi[0]); hi_b += int'(pwm_hi[1]); hi_c += int'(pwm_hi[2]);
    end
    vn = vec_code(s); vm = vec_code(next_sec(s));
    chk(hi_a == a + 2 * ((vn[0] ? b : 0) + (vm[0] ? c : 0)), "R4 on-time A", hi_a,
        a + 2 * ((vn[0] ? b : 0) + (vm[0] ? c : 0)));
    chk(hi_b == a + 2 * ((vn[1] ? b : 0) + (vm[1] ? c : 0)), "R4 on-time B", hi_b,
        a + 2 * ((vn[1] ? b : 0) + (vm[1] ? c : 0)));
    chk(hi_c == a + 2 * ((vn[2] ? b : 0) + (vm[2] ? c : 0)), "R4 on-time C", hi_c,
        a + 2 * ((vn[2] ? b : 0) + (vm[2] ? c : 0)));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int gap, rise1, rise2, run_all, run_none;
    void'($urandom(32'h5EED_0A11));

    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(pwm_hi == 3'b000, "R1 upper in reset", int'(pwm_hi), 0);
    chk(pwm_lo == 3'b111, "R1 lower in reset", int'(pwm_lo), 7);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_hi == 3'b000, "R1 upper after reset", int'(pwm_hi), 0);
    chk(pwm_lo == 3'b111, "R1 lower after reset", int'(pwm_lo), 7);
    mon_en = 1;

    // R3: directed sector 1 edges
    cur_tag = "R3 sector-1 pattern";
    do_load(1, 4, 3, 2);
    wait_wraps(3);

    // R2: leading-leg rise spacing equals 2*(T0+T1+T2) = 18
    while (pwm_hi[0] !== 1'b0) @(negedge clk);
    while (pwm_hi[0] !== 1'b1) @(negedge clk);
    rise1 = cyc;
    @(negedge clk);
    while (pwm_hi[0] !== 1'b0) @(negedge clk);
    while (pwm_hi[0] !== 1'b1) @(negedge clk);
    rise2 = cyc;
    chk(rise2 - rise1 == 18, "R2 period length", rise2 - rise1, 18);

    // R4: on-time table for every sector
    cur_tag = "R4 sector table";
    for (int s = 1; s <= 6; s++) check_duty(s, 6, 5, 2);

    // R7: odd T0, run lengths and cycle-exact placement through the model
    cur_tag = "R7 odd zero time";
    do_load(2, 5, 2, 1);
    wait_wraps(2);
    while (pwm_hi !== 3'b111) @(negedge clk);
    run_all = 0;
    while (pwm_hi === 3'b111) begin run_all++; @(negedge clk); end
    chk(run_all == 5, "R7 all-high run", run_all, 5);
    while (pwm_hi !== 3'b000) @(negedge clk);
    run_none = 0;
    while (pwm_hi === 3'b000) begin run_none++; @(negedge clk); end
    chk(run_none == 5, "R7 all-low run across wrap", run_none, 5);
    wait_wraps(2);

    // R8: invalid sectors
    cur_tag = "R8 invalid sector";
    do_load(0, 4, 4, 4);
    wait_wraps(2);
    do_load(7, 3, 2, 1);
    wait_wraps(2);

    // R6: two loads inside one period, only the later one applies
    cur_tag = "R6 staging";
    do_load(3, 6, 4, 4);
    wait_wraps(2);
    repeat (5) @(negedge clk);
    do_load(5, 1, 1, 1);
    do_load(4, 2, 6, 3);
    wait_wraps(2);
    check_duty(4, 2, 6, 3);

    // R6: load on the wrap cycle itself
    cur_tag = "R6 load at wrap";
    do_load(1, 3, 3, 3);
    wait_wraps(2);
    while (!(m_cnt == per_of(m_t0, m_t1, m_t2))) @(negedge clk);
    load = 1'b1; sector = 3'd6; t0 = 8'd2; t1 = 8'd1; t2 = 8'd4;
    @(negedge clk);
    load = 1'b0;
    chk(m_sec == 6, "R6 wrap-cycle load active", m_sec, 6);
    wait_wraps(2);

    // Constrained random mix
    cur_tag = "R4 random";
    for (int i = 0; i < 40; i++) begin
      int s;
      s = ($urandom_range(0, 9) == 0) ? 7 * int'($urandom_range(0, 1)) : int'($urandom_range(1, 6));
      do_load(s, int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
              int'($urandom_range(0, 12)));
      gap = int'($urandom_range(0, 40));
      repeat (gap) @(negedge clk);
    end
    wait_wraps(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule